// File: doc/BRIEF.md
# Microword Load-Destination and Right-Bus Decoder with Chained Address Register

This block sits in the control path of a small 8-bit datapath. Each cycle it takes the current 24-bit microinstruction and decodes two of its fields. A 3-bit destination field selects which register captures the data bus. A 2-bit source field selects which driver places its value on the right ALU operand bus. Load enables are active-high and one-hot, and they are gated by a global load strobe. Right-bus driver enables are active-low and one-hot, and they are gated by a bus-active input.

The 16-bit address register and a Y index register live inside the block. The address register has no separate low and high load codes. It has a single chained load code. On that load, the high byte takes the data bus and the low byte takes the old high byte, both on the same edge. Software therefore fills the address by loading the low byte value first and the high byte value second. The halves cannot be written on their own. This frees one destination code, and that code loads Y. Y is also one of the four right-bus sources. The accumulator, X, T, the program counter halves and the memory write are outside the block and see only their load enables.

Top module: `uw_route_top`

## Requirements
- R1: On reset, the address register and Y both clear to zero.
- R2: While the load strobe is low, all eight load enables are low, whatever the destination field holds.
- R3: While the load strobe is high, exactly one load enable is high in the same cycle. Its bit index equals the destination code: 0 A, 1 X, 2 T, 3 PC low, 4 PC high, 5 address chain, 6 Y, 7 memory write.
- R4: On a chained address load (code 5 with the strobe), the next edge puts the data bus into address bits 15:8 and the previous bits 15:8 into bits 7:0.
- R5: Two chained loads in a row, with value L and then value H, leave the address register holding {H, L}.
- R6: A Y load (code 6 with the strobe) captures the data bus into Y at the next edge. Any cycle without a Y load leaves Y unchanged. Any cycle without a chained load leaves the address register unchanged.
- R7: While the bus-active input is high, exactly one right-bus enable is low. Its index equals the source code: 0 X, 1 T, 2 constant/data, 3 Y.
- R8: While the bus-active input is low, all four right-bus enables are high.
- R9: The destination field occupies microword bits 23:21 and the source field occupies bits 20:19. Bits 18:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| uword | input | 24 | Current microinstruction |
| ld_strobe | input | 1 | Global load strobe; gates all load enables |
| rbus_act | input | 1 | Right-bus active; gates all right-bus drivers |
| dbus | input | 8 | Data bus value to be captured |
| ld_en | output | 8 | One-hot load enables, index = destination code |
| rbus_oe_n | output | 4 | Active-low right-bus driver enables, index = source code |
| ar_q | output | 16 | Address register |
| y_q | output | 8 | Y register |

## Verification
The bench builds the block with its default parameters: 8-bit data, a two-byte address chain, and fields at bits 23:21 and 20:19. These values let it walk all eight destination codes and all four source codes, with and without their gates. It fills the address register byte by byte and checks the shift of the old high byte into the low half. It also holds Y and the address register across every code other than their own. Sweeping the low 19 microword bits under a fixed field pair shows that only the two fields steer the outputs.

// File: rtl/uw_route_pkg.sv
package uw_route_pkg;
    localparam int DEST_W = 3;
    localparam int RSRC_W = 2;
    localparam int N_DEST = 1 << DEST_W;
    localparam int N_RSRC = 1 << RSRC_W;

    typedef enum logic [DEST_W-1:0] {
        DST_ACC  = 3'd0,
        DST_XR   = 3'd1,
        DST_TMP  = 3'd2,
        DST_PCL  = 3'd3,
        DST_PCH  = 3'd4,
        DST_ADDR = 3'd5,
        DST_YR   = 3'd6,
        DST_WR   = 3'd7
    } dest_e;

    typedef enum logic [RSRC_W-1:0] {
        RSRC_XR    = 2'd0,
        RSRC_TMP   = 2'd1,
        RSRC_CONST = 2'd2,
        RSRC_YR    = 2'd3
    } rsrc_e;
endpackage

// File: rtl/uw_dest_decode.sv
module uw_dest_decode
    import uw_route_pkg::*;
(
    input  logic              strobe,
    input  dest_e             code,
    output logic [N_DEST-1:0] ld
);
    always_comb begin
        ld = '0;
        if (strobe) begin
            unique case (code)
                DST_ACC:  ld[0] = 1'b1;
                DST_XR:   ld[1] = 1'b1;
                DST_TMP:  ld[2] = 1'b1;
                DST_PCL:  ld[3] = 1'b1;
                DST_PCH:  ld[4] = 1'b1;
                DST_ADDR: ld[5] = 1'b1;
                DST_YR:   ld[6] = 1'b1;
                DST_WR:   ld[7] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uw_rbus_decode.sv
module uw_rbus_decode
    import uw_route_pkg::*;
(
    input  logic              active,
    input  rsrc_e             code,
    output logic [N_RSRC-1:0] oe_n
);
    always_comb begin
        oe_n = '1;
        if (active) begin
            unique case (code)
                RSRC_XR:    oe_n[0] = 1'b0;
                RSRC_TMP:   oe_n[1] = 1'b0;
                RSRC_CONST: oe_n[2] = 1'b0;
                RSRC_YR:    oe_n[3] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/uw_byte_reg.sv
module uw_byte_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/uw_route_top.sv
module uw_route_top
    import uw_route_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int DATA_W   = 8,
    parameter int AR_BYTES = 2,
    parameter int DEST_LSB = 21,
    parameter int RSRC_LSB = 19
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WORD_W-1:0]          uword,
    input  logic                       ld_strobe,
    input  logic                       rbus_act,
    input  logic [DATA_W-1:0]          dbus,
    output logic [N_DEST-1:0]          ld_en,
    output logic [N_RSRC-1:0]          rbus_oe_n,
    output logic [AR_BYTES*DATA_W-1:0] ar_q,
    output logic [DATA_W-1:0]          y_q
);
    localparam int AR_W = AR_BYTES * DATA_W;

    dest_e dest_code;
    rsrc_e rsrc_code;
    assign dest_code = dest_e'(uword[DEST_LSB +: DEST_W]);
    assign rsrc_code = rsrc_e'(uword[RSRC_LSB +: RSRC_W]);

    uw_dest_decode i_dest (
        .strobe (ld_strobe),
        .code   (dest_code),
        .ld     (ld_en)
    );

    uw_rbus_decode i_rbus (
        .active (rbus_act),
        .code   (rsrc_code),
        .oe_n   (rbus_oe_n)
    );

    // Address chain: top byte takes the data bus, each lower byte the one above.
    logic [AR_W-1:0] ar_d;
    generate
        for (genvar b = 0; b < AR_BYTES; b++) begin : g_ar
            if (b == AR_BYTES - 1) begin : g_top
                assign ar_d[b*DATA_W +: DATA_W] = dbus;
            end else begin : g_link
                assign ar_d[b*DATA_W +: DATA_W] = ar_q[(b+1)*DATA_W +: DATA_W];
            end
            uw_byte_reg #(.W(DATA_W)) i_byte (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (ld_en[DST_ADDR]),
                .d     (ar_d[b*DATA_W +: DATA_W]),
                .q     (ar_q[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    uw_byte_reg #(.W(DATA_W)) i_yreg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ld_en[DST_YR]),
        .d     (dbus),
        .q     (y_q)
    );
endmodule

// File: rtl/uw_route_chk.sv
module uw_route_chk
    import uw_route_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int AR_BYTES = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ld_strobe,
    input logic                       rbus_act,
    input logic [DATA_W-1:0]          dbus,
    input logic [N_DEST-1:0]          ld_en,
    input logic [N_RSRC-1:0]          rbus_oe_n,
    input logic [AR_BYTES*DATA_W-1:0] ar_q,
    input logic [DATA_W-1:0]          y_q
);
    localparam int AR_W = AR_BYTES * DATA_W;

    a_r2_no_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_strobe |-> (ld_en == '0));

    a_r3_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_strobe |-> ($countones(ld_en) == 1));

    a_r4_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en[DST_ADDR] |=> (ar_q[AR_W-1 -: DATA_W] == $past(dbus)) &&
                            (ar_q[AR_W-DATA_W-1:0] == $past(ar_q[AR_W-1:DATA_W])));

    a_r6_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en[DST_ADDR] |=> $stable(ar_q));

    a_r6_y_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en[DST_YR] |=> (y_q == $past(dbus)));

    a_r6_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en[DST_YR] |=> $stable(y_q));

    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        rbus_act |-> ($countones(~rbus_oe_n) == 1));

    a_r8_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rbus_act |-> (rbus_oe_n == '1));
endmodule

bind uw_route_top uw_route_chk #(
    .DATA_W   (DATA_W),
    .AR_BYTES (AR_BYTES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_strobe (ld_strobe),
    .rbus_act  (rbus_act),
    .dbus      (dbus),
    .ld_en     (ld_en),
    .rbus_oe_n (rbus_oe_n),
    .ar_q      (ar_q),
    .y_q       (y_q)
);

// File: tb/test_uw_route_top.sv
module test_uw_route_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] uword = '0;
    logic        ld_strobe = 1'b0;
    logic        rbus_act = 1'b0;
    logic [7:0]  dbus = '0;
    logic [7:0]  ld_en;
    logic [3:0]  rbus_oe_n;
    logic [15:0] ar_q;
    logic [7:0]  y_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uw_route_top i_uw_route_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .uword     (uword),
        .ld_strobe (ld_strobe),
        .rbus_act  (rbus_act),
        .dbus      (dbus),
        .ld_en     (ld_en),
        .rbus_oe_n (rbus_oe_n),
        .ar_q      (ar_q),
        .y_q       (y_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply a microword at the falling edge; fields at 23:21 and 20:19.
    task automatic apply(input logic [2:0] dst, input logic [1:0] src, input logic stb,
                         input logic act, input logic [7:0] d, input logic [18:0] spare);
        @(negedge clk);
        uword     = {dst, src, spare};
        ld_strobe = stb;
        rbus_act  = act;
        dbus      = d;
        #1;
    endtask

    task automatic idle_after();
        @(negedge clk);
        ld_strobe = 1'b0;
        rbus_act  = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 ar after reset", ar_q, 0);
        check("R1 y after reset", y_q, 0);
        check("R2 no load during reset idle", ld_en, 0);
        check("R8 bus idle after reset", rbus_oe_n, 4'hF);
    endtask

    task automatic t_strobe_low();
        for (int c = 0; c < 8; c++) begin
            apply(c[2:0], 2'd0, 1'b0, 1'b0, 8'hC3, 19'h0);
            check("R2 strobe low", ld_en, 0);
        end
        idle_after();
        check("R6 ar untouched by strobe-low", ar_q, 0);
        check("R6 y untouched by strobe-low", y_q, 0);
    endtask

    task automatic t_dest_codes();
        for (int c = 0; c < 8; c++) begin
            if (c == 5 || c == 6) continue;
            apply(c[2:0], 2'd0, 1'b1, 1'b0, 8'h3C, 19'h0);
            check("R3 one-hot load", ld_en, 32'h1 << c);
        end
        idle_after();
        check("R6 ar held across other codes", ar_q, 0);
        check("R6 y held across other codes", y_q, 0);
    endtask

    task automatic t_ar_chain();
        apply(3'd5, 2'd0, 1'b1, 1'b0, 8'h34, 19'h0);
        check("R3 chain code enable", ld_en, 8'h20);
        apply(3'd5, 2'd0, 1'b1, 1'b0, 8'h12, 19'h0);
        check("R4 first chain load", ar_q, 16'h3400);
        idle_after();
        check("R5 pair fill", ar_q, 16'h1234);
        apply(3'd5, 2'd0, 1'b1, 1'b0, 8'hAB, 19'h0);
        idle_after();
        check("R4 shift old high into low", ar_q, 16'hAB12);
    endtask

    task automatic t_y_reg();
        apply(3'd6, 2'd0, 1'b1, 1'b0, 8'h5A, 19'h0);
        check("R3 y code enable", ld_en, 8'h40);
        idle_after();
        check("R6 y load", y_q, 8'h5A);
        check("R6 ar held during y load", ar_q, 16'hAB12);
        for (int c = 0; c < 8; c++) begin
            if (c == 5 || c == 6) continue;
            apply(c[2:0], 2'd0, 1'b1, 1'b0, 8'hFF, 19'h0);
        end
        idle_after();
        check("R6 y held", y_q, 8'h5A);
        check("R6 ar held", ar_q, 16'hAB12);
    endtask

    task automatic t_rbus();
        for (int s = 0; s < 4; s++) begin
            apply(3'd0, s[1:0], 1'b0, 1'b1, 8'h00, 19'h0);
            check("R7 active-low one-hot driver", rbus_oe_n, ~(4'h1 << s) & 4'hF);
        end
        for (int s = 0; s < 4; s++) begin
            apply(3'd0, s[1:0], 1'b0, 1'b0, 8'h00, 19'h0);
            check("R8 idle bus", rbus_oe_n, 4'hF);
        end
        idle_after();
    endtask

    task automatic t_spare_bits();
        logic [18:0] pat [4] = '{19'h00000, 19'h7FFFF, 19'h2AAAA, 19'h15555};
        for (int p = 0; p < 4; p++) begin
            apply(3'd3, 2'd2, 1'b1, 1'b1, 8'h00, pat[p]);
            check("R9 dest field only", ld_en, 8'h08);
            check("R9 source field only", rbus_oe_n, 4'hB);
        end
        idle_after();
        check("R9 spare bits leave ar", ar_q, 16'hAB12);
        check("R9 spare bits leave y", y_q, 8'h5A);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 ar cleared by reset", ar_q, 0);
        check("R1 y cleared by reset", y_q, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_strobe_low();
        t_dest_codes();
        t_ar_chain();
        t_y_reg();
        t_rbus();
        t_spare_bits();
        t_reset_again();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule